// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the address for a four-beat burst on a synchronous SRAM port. On any rising clock edge it either captures a start address from the external address bus, steps to the next beat of the burst, or keeps the current beat. Only the two lowest address bits take part in the burst. The upper bits are taken from the captured address and stay unchanged until the next capture.

A static order-select input chooses how the beats are visited. In linear order each beat adds one, modulo four, to the start offset. In interleaved order beat n uses the start offset XOR n. Internally a 2-bit beat index counts 0 to 3. The low output bits are formed by adding the start offset to this index, or by XORing the two, so the fifth beat wraps back to the start address. The beat index is also an output, so the surrounding logic can see how far the burst has gone.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the output address and the beat index to zero.
- R2: When strobe_cpu_n or strobe_ctl_n is low at a rising edge, the output address becomes addr_in and the beat index becomes 0 after that edge.
- R3: A capture takes priority over an advance: with a strobe low and adv_n low, the beat index still becomes 0 and the address becomes addr_in.
- R4: With both strobes high and adv_n low, the beat index increments by one modulo 4 at the edge.
- R5: With both strobes high and adv_n high, the beat index and the output address are unchanged.
- R6: With order_sel low (linear), addr_out[1:0] equals (start offset + beat index) modulo 4.
- R7: With order_sel high (interleaved), addr_out[1:0] equals start offset XOR beat index.
- R8: Four advances after a capture return the address to the captured start address, with beat index 0.
- R9: addr_out above bit 1 keeps the captured value on every edge without a capture, whatever addr_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| addr_in | input | ADDR_W | External address bus |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Beat number within the burst, 0 to 3 |

## Verification
Every cycle, the assertions check the edge-to-edge rules: a capture loads addr_in with beat 0, an advance increments the index, a hold freezes it, the upper bits hold between captures, and reset clears all state. The actual beat orders, the wrap on the fifth beat and the effect of order_sel on the low bits are shown only by the bench's scenarios, which compare addr_out against hand-computed sequences from several start offsets in both modes.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              order_sel,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_idx
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q;
  logic [1:0]      beat_q;
  logic            load;
  logic            step;
  logic [1:0]      low_bits;

  assign load = !strobe_cpu_n || !strobe_ctl_n;
  assign step = !load && !adv_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      hi_q    <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign low_bits = order_sel ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_out = {hi_q, low_bits};
  assign beat_idx = beat_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && (beat_idx == 2'd0));

  // R2 R3
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu_n || !strobe_ctl_n) |=> (addr_out == $past(addr_in)) && (beat_idx == 2'd0));

  // R4
  advance_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_cpu_n && strobe_ctl_n && !adv_n) |=> beat_idx == $past(beat_idx) + 2'd1);

  // R5
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_cpu_n && strobe_ctl_n && adv_n) |=> $stable(beat_idx));

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_cpu_n && strobe_ctl_n) |=> $stable(addr_out[ADDR_W-1:2]));

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 18;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          order_sel = 1'b1;
  logic          strobe_cpu_n = 1'b1;
  logic          strobe_ctl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .order_sel(order_sel),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .adv_n(adv_n), .addr_in(addr_in),
    .addr_out(addr_out), .beat_idx(beat_idx)
  );

  // {cpu_n, ctl_n, adv_n, order, addr_in, expected addr_out, expected beat}
  localparam logic [41:0] VEC [NV] = '{
    {4'b0110, 18'h15551, 18'h15551, 2'd0}, // R2 capture, linear, start 01
    {4'b1100, 18'h00000, 18'h15552, 2'd1}, // R6
    {4'b1100, 18'h00000, 18'h15553, 2'd2}, // R6
    {4'b1100, 18'h00000, 18'h15550, 2'd3}, // R6 modulo wrap of offset
    {4'b1100, 18'h00000, 18'h15551, 2'd0}, // R8 fifth beat
    {4'b1110, 18'h3FFFF, 18'h15551, 2'd0}, // R5 hold
    {4'b1011, 18'h0AAAA, 18'h0AAAA, 2'd0}, // R2 controller strobe, interleaved, start 10
    {4'b1101, 18'h00000, 18'h0AAAB, 2'd1}, // R7
    {4'b1101, 18'h00000, 18'h0AAA8, 2'd2}, // R7
    {4'b1101, 18'h3FFFF, 18'h0AAA9, 2'd3}, // R9 upper ignores bus
    {4'b1101, 18'h00000, 18'h0AAAA, 2'd0}, // R8
    {4'b0001, 18'h12343, 18'h12343, 2'd0}, // R3 both strobes with advance
    {4'b1101, 18'h00000, 18'h12342, 2'd1}, // R7 3^1
    {4'b1111, 18'h00000, 18'h12342, 2'd1}, // R5
    {4'b1101, 18'h00000, 18'h12341, 2'd2}, // R7 3^2
    {4'b1101, 18'h00000, 18'h12340, 2'd3}, // R7 3^3
    {4'b1101, 18'h00000, 18'h12343, 2'd0}, // R8
    {4'b0110, 18'h00007, 18'h00007, 2'd0}, // R2 linear start 11
    {4'b1100, 18'h00000, 18'h00004, 2'd1}  // R4 R6 3+1 wraps to 00
  };

  function automatic string tag_of(int i);
    case (i)
      0, 6, 17:    return "R2";
      1, 2, 3:     return "R6";
      4, 10, 16:   return "R8";
      5, 13:       return "R5";
      7, 8, 12, 14, 15: return "R7";
      9:           return "R9";
      11:          return "R3";
      default:     return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] ea, logic [1:0] eb);
    n_chk++;
    if (addr_out !== ea || beat_idx !== eb) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
               tag, addr_out, beat_idx, ea, eb);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", '0, 2'd0);
    for (int i = 0; i < NV; i++) begin
      {strobe_cpu_n, strobe_ctl_n, adv_n, order_sel, addr_in} = VEC[i][41:20];
      @(posedge clk);
      @(negedge clk);
      check(tag_of(i), VEC[i][19:2], VEC[i][1:0]);
    end
    // R4 directed: index climbs 0..3 and wraps, linear from 00
    {strobe_cpu_n, strobe_ctl_n, adv_n, order_sel, addr_in} = {4'b0110, 18'h20000};
    @(posedge clk); @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      {strobe_cpu_n, strobe_ctl_n, adv_n} = 3'b110;
      @(posedge clk); @(negedge clk);
      check("R4", 18'h20000 | AW'(k % 4), 2'(k % 4));
    end
    // R1 mid-burst reset
    adv_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b1; adv_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", '0, 2'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", '0, 2'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule